// File: doc/BRIEF.md
# Three-Wire Serial Programming Register with Latch Decode

This block is the write-only programming port of a frequency-synthesizer control core. A host sends 24-bit words over three lines: a serial clock, a serial data line and a load-enable strobe. Each word enters an input shift register most significant bit first. When the load-enable line rises, the two bits received last choose where the other 22 bits go. The destinations are a reference latch, a divider latch and a function latch. The fourth code writes the function latch and also emits a one-cycle counter-reset pulse.

The three serial lines are oversampled by a faster system clock. Each line passes through a synchronizer of `SYNC_DEPTH` flops, and the serial clock and load-enable are then edge-detected. All decoded fields leave the block directly from the latch flops. A control module turns the detected edges and the select bits into a small strobe struct. A datapath module holds the shift register and the latches.

Top module: `serial_latch_port`

## Requirements
- R1: A frame is 24 bits, sent first bit first. The first bit sent ends up as frame bit 23 and the last bit sent as frame bit 0.
- R2: A data bit is captured only on a rising edge of the serial clock. Changes of the data line while the serial clock holds steady have no effect.
- R3: On a rising edge of load-enable, frame bits 1:0 pick the destination: 00 reference latch, 01 divider latch, 10 function latch, 11 function latch plus counter-reset pulse.
- R4: Reference latch fields: refDiv = frame bits 15:2, abWidth = bits 17:16, testBits = bits 19:18, ldPrec = bit 20.
- R5: Divider latch fields: aVal = frame bits 7:2, bVal = bits 20:8, gainBit = bit 21.
- R6: Function latch fields: fnF1 = bit 2, pd1 = bit 3, muxSel = bits 6:4, fnMode = bits 10:7, timerCode = bits 14:11, cpCur1 = bits 17:15, cpCur2 = bits 20:18, pd2 = bit 21, presc = bits 23:22.
- R7: Code 11 raises cntRstPulse for exactly one system clock cycle. Code 10 never raises it.
- R8: A load changes only the addressed latch. The other latches keep their values.
- R9: After reset every output is zero.
- R10: With SYNC_DEPTH = 2, the latch outputs change on the third rising system clock edge after load-enable goes high.
- R11: If more than 24 bits arrive before load-enable, only the last 24 bits received form the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock line |
| serData | input | 1 | Serial data line |
| serLe | input | 1 | Load-enable strobe line |
| refDiv | output | 14 | Reference divide value |
| abWidth | output | 2 | Anti-backlash width code |
| testBits | output | 2 | Test mode bits |
| ldPrec | output | 1 | Lock-detect precision bit |
| aVal | output | 6 | A counter value |
| bVal | output | 13 | B counter value |
| gainBit | output | 1 | Divider latch gain bit |
| fnF1 | output | 1 | Function bit F1 |
| pd1 | output | 1 | Power-down bit 1 |
| muxSel | output | 3 | Output multiplexer select |
| fnMode | output | 4 | Function bits F5..F2 |
| timerCode | output | 4 | Timer counter code |
| cpCur1 | output | 3 | Charge-pump current setting 1 |
| cpCur2 | output | 3 | Charge-pump current setting 2 |
| pd2 | output | 1 | Power-down bit 2 |
| presc | output | 2 | Prescaler select |
| cntRstPulse | output | 1 | One-cycle counter-reset pulse |

## Verification
The bench builds the block with SYNC_DEPTH = 2. That fixes the exact three-edge load latency, which the bench checks cycle by cycle. Each serial phase is held for three system clock periods. This is close to the shortest phase the two-flop pipeline can resolve, so data hold and capture alignment are exercised near their limit. Over-length frames and data wiggles without clock edges show that only qualified rising edges and the last 24 bits count.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int FRAME_W   = 24;
  localparam int SEL_W     = 2;
  localparam int PAYLOAD_W = FRAME_W - SEL_W;
  localparam int NUM_LATCH = 3;
  localparam int IDX_REF   = 0;
  localparam int IDX_N     = 1;
  localparam int IDX_FN    = 2;

  typedef enum logic [SEL_W-1:0] {
    DEST_REF  = 2'b00,
    DEST_N    = 2'b01,
    DEST_FN   = 2'b10,
    DEST_INIT = 2'b11
  } dest_e;

  typedef struct packed {
    logic                 shift;
    logic [NUM_LATCH-1:0] load;
    logic                 initPulse;
  } strobe_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic syncOut,
  output logic syncPrev
);
  logic [DEPTH:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-1:0], din};
  end

  assign syncOut  = pipe[DEPTH-1];
  assign syncPrev = pipe[DEPTH];
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ckNow,
  input  logic             ckPrev,
  input  logic             leNow,
  input  logic             lePrev,
  input  logic [SEL_W-1:0] selBits,
  output strobe_t          stb
);
  logic ckRise, leRise;

  assign ckRise = ckNow & ~ckPrev;
  assign leRise = leNow & ~lePrev;

  always_comb begin
    stb           = '0;
    stb.shift     = ckRise;
    if (leRise) begin
      unique case (dest_e'(selBits))
        DEST_REF:  stb.load[IDX_REF] = 1'b1;
        DEST_N:    stb.load[IDX_N]   = 1'b1;
        DEST_FN:   stb.load[IDX_FN]  = 1'b1;
        DEST_INIT: begin
          stb.load[IDX_FN] = 1'b1;
          stb.initPulse    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb.load));

  // R7
  init_implies_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.initPulse |-> stb.load[IDX_FN]);

  // R3
  le_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load != '0) |=> (stb.load == '0));
endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dataBit,
  input  strobe_t          stb,
  output logic [SEL_W-1:0] selBits,
  output logic [13:0]      refDiv,
  output logic [1:0]       abWidth,
  output logic [1:0]       testBits,
  output logic             ldPrec,
  output logic [5:0]       aVal,
  output logic [12:0]      bVal,
  output logic             gainBit,
  output logic             fnF1,
  output logic             pd1,
  output logic [2:0]       muxSel,
  output logic [3:0]       fnMode,
  output logic [3:0]       timerCode,
  output logic [2:0]       cpCur1,
  output logic [2:0]       cpCur2,
  output logic             pd2,
  output logic [1:0]       presc,
  output logic             cntRstPulse
);
  logic [FRAME_W-1:0]   shiftReg;
  logic [PAYLOAD_W-1:0] latchWord [NUM_LATCH];

  always_ff @(posedge clk) begin
    if (!rst_n)         shiftReg <= '0;
    else if (stb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], dataBit};
  end

  assign selBits = shiftReg[SEL_W-1:0];

  for (genvar gi = 0; gi < NUM_LATCH; gi++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rst_n)            latchWord[gi] <= '0;
      else if (stb.load[gi]) latchWord[gi] <= shiftReg[FRAME_W-1:SEL_W];
    end

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.load[gi] |=> $stable(latchWord[gi]));

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb.load[gi] |=> (latchWord[gi] == $past(shiftReg[FRAME_W-1:SEL_W])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cntRstPulse <= 1'b0;
    else        cntRstPulse <= stb.initPulse;
  end

  // Reference latch fields
  assign refDiv   = latchWord[IDX_REF][13:0];
  assign abWidth  = latchWord[IDX_REF][15:14];
  assign testBits = latchWord[IDX_REF][17:16];
  assign ldPrec   = latchWord[IDX_REF][18];
  wire   unusedRefHi = ^latchWord[IDX_REF][PAYLOAD_W-1:19];

  // Divider latch fields
  assign aVal     = latchWord[IDX_N][5:0];
  assign bVal     = latchWord[IDX_N][18:6];
  assign gainBit  = latchWord[IDX_N][19];
  wire   unusedNHi = ^latchWord[IDX_N][PAYLOAD_W-1:20];

  // Function latch fields
  assign fnF1      = latchWord[IDX_FN][0];
  assign pd1       = latchWord[IDX_FN][1];
  assign muxSel    = latchWord[IDX_FN][4:2];
  assign fnMode    = latchWord[IDX_FN][8:5];
  assign timerCode = latchWord[IDX_FN][12:9];
  assign cpCur1    = latchWord[IDX_FN][15:13];
  assign cpCur2    = latchWord[IDX_FN][18:16];
  assign pd2       = latchWord[IDX_FN][19];
  assign presc     = latchWord[IDX_FN][21:20];

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.shift |=> $stable(shiftReg));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntRstPulse |=> !cntRstPulse);
endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port
  import slp_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLe,
  output logic [13:0] refDiv,
  output logic [1:0]  abWidth,
  output logic [1:0]  testBits,
  output logic        ldPrec,
  output logic [5:0]  aVal,
  output logic [12:0] bVal,
  output logic        gainBit,
  output logic        fnF1,
  output logic        pd1,
  output logic [2:0]  muxSel,
  output logic [3:0]  fnMode,
  output logic [3:0]  timerCode,
  output logic [2:0]  cpCur1,
  output logic [2:0]  cpCur2,
  output logic        pd2,
  output logic [1:0]  presc,
  output logic        cntRstPulse
);
  logic ckNow, ckPrev, leNow, lePrev, dataNow, unusedDataPrev;
  logic [SEL_W-1:0] selBits;
  strobe_t stb;

  slp_sync #(.DEPTH(SYNC_DEPTH)) u_sync_ck (
    .clk(clk), .rst_n(rst_n), .din(serClk), .syncOut(ckNow), .syncPrev(ckPrev));
  slp_sync #(.DEPTH(SYNC_DEPTH)) u_sync_le (
    .clk(clk), .rst_n(rst_n), .din(serLe), .syncOut(leNow), .syncPrev(lePrev));
  slp_sync #(.DEPTH(SYNC_DEPTH)) u_sync_d (
    .clk(clk), .rst_n(rst_n), .din(serData), .syncOut(dataNow), .syncPrev(unusedDataPrev));

  slp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ckNow(ckNow), .ckPrev(ckPrev),
    .leNow(leNow), .lePrev(lePrev), .selBits(selBits), .stb(stb));

  slp_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .dataBit(dataNow), .stb(stb), .selBits(selBits),
    .refDiv(refDiv), .abWidth(abWidth), .testBits(testBits), .ldPrec(ldPrec),
    .aVal(aVal), .bVal(bVal), .gainBit(gainBit),
    .fnF1(fnF1), .pd1(pd1), .muxSel(muxSel), .fnMode(fnMode),
    .timerCode(timerCode), .cpCur1(cpCur1), .cpCur2(cpCur2), .pd2(pd2),
    .presc(presc), .cntRstPulse(cntRstPulse));
endmodule

// File: tb/serial_latch_port_tb_top.sv
`timescale 1ns/1ps
module serial_latch_port_tb_top;
  localparam int SD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLe = 1'b0;

  logic [13:0] refDiv; logic [1:0] abWidth, testBits; logic ldPrec;
  logic [5:0] aVal; logic [12:0] bVal; logic gainBit;
  logic fnF1, pd1; logic [2:0] muxSel; logic [3:0] fnMode, timerCode;
  logic [2:0] cpCur1, cpCur2; logic pd2; logic [1:0] presc; logic cntRstPulse;

  always #4 clk = ~clk;

  serial_latch_port #(.SYNC_DEPTH(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData), .serLe(serLe),
    .refDiv(refDiv), .abWidth(abWidth), .testBits(testBits), .ldPrec(ldPrec),
    .aVal(aVal), .bVal(bVal), .gainBit(gainBit), .fnF1(fnF1), .pd1(pd1),
    .muxSel(muxSel), .fnMode(fnMode), .timerCode(timerCode), .cpCur1(cpCur1),
    .cpCur2(cpCur2), .pd2(pd2), .presc(presc), .cntRstPulse(cntRstPulse));

  int checks = 0, errors = 0, cyc = 0, pulseCnt = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: history of sampled lines and a bit queue
  logic [SD:0] ckH, leH;
  logic [SD-1:0] dH;
  bit bitQ[$];
  logic [21:0] mRef, mN, mFn;
  logic mPulse;

  function automatic logic [23:0] lastFrame();
    logic [23:0] f = '0;
    for (int i = 0; i < 24; i++)
      if (bitQ.size() > i) f[i] = bitQ[bitQ.size()-1-i];
    return f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ckH <= '0; leH <= '0; dH <= '0; bitQ.delete();
      mRef <= '0; mN <= '0; mFn <= '0; mPulse <= 1'b0;
    end else begin
      logic [23:0] fr;
      ckH <= {ckH[SD-1:0], serClk};
      leH <= {leH[SD-1:0], serLe};
      dH  <= {dH[SD-2:0], serData};
      fr = lastFrame();
      if (ckH[SD-1] && !ckH[SD]) begin
        bitQ.push_back(dH[SD-1]);
        if (bitQ.size() > 24) void'(bitQ.pop_front());
      end
      mPulse <= 1'b0;
      if (leH[SD-1] && !leH[SD]) begin
        case (fr[1:0])
          2'b00: mRef <= fr[23:2];
          2'b01: mN   <= fr[23:2];
          2'b10: mFn  <= fr[23:2];
          default: begin mFn <= fr[23:2]; mPulse <= 1'b1; end
        endcase
      end
    end
  end

  wire [61:0] actBus = {refDiv, abWidth, testBits, ldPrec, aVal, bVal, gainBit,
                        fnF1, pd1, muxSel, fnMode, timerCode, cpCur1, cpCur2,
                        pd2, presc, cntRstPulse};
  wire [61:0] expBus = {mRef[13:0], mRef[15:14], mRef[17:16], mRef[18],
                        mN[5:0], mN[18:6], mN[19],
                        mFn[0], mFn[1], mFn[4:2], mFn[8:5], mFn[12:9],
                        mFn[15:13], mFn[18:16], mFn[19], mFn[21:20], mPulse};

  // R10 cycle-exact comparison of every output against the model
  always @(negedge clk) begin
    if (rst_n) chk("R10 per-cycle outputs", {2'b0, actBus}, {2'b0, expBus});
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && cntRstPulse) pulseCnt++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); serData = v[i];
      repeat (3) @(negedge clk); serClk = 1'b1;
      repeat (3) @(negedge clk); serClk = 1'b0;
    end
  endtask

  task automatic strobeLe();
    @(negedge clk); serLe = 1'b1;
    repeat (3) @(negedge clk); serLe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [23:0] refFrame(logic [13:0] d, logic [1:0] ab, logic [1:0] t, logic l);
    return {3'b000, l, t, ab, d, 2'b00};
  endfunction
  function automatic logic [23:0] nFrame(logic [5:0] a, logic [12:0] b, logic g);
    return {2'b00, g, b, a, 2'b01};
  endfunction

  logic [23:0] frRef, frN, frFn, frInit, frRef2, frN2;
  logic [21:0] fnAct;
  assign fnAct = {presc, pd2, cpCur2, cpCur1, timerCode, fnMode, muxSel, pd1, fnF1};

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {2'b0, actBus}, 64'd0);

    // R1 R4 R10: reference frame with latency probe
    frRef = refFrame(14'h2A5B, 2'b10, 2'b01, 1'b1);
    sendBits({8'h0, frRef}, 24);
    @(negedge clk); serLe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 before third edge", {50'd0, refDiv}, 64'd0);
    @(negedge clk);
    chk("R10 at third edge", {50'd0, refDiv}, {50'd0, frRef[15:2]});
    repeat (2) @(negedge clk); serLe = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 refDiv", {50'd0, refDiv}, {50'd0, frRef[15:2]});
    chk("R4 abWidth", {62'd0, abWidth}, {62'd0, frRef[17:16]});
    chk("R4 testBits", {62'd0, testBits}, {62'd0, frRef[19:18]});
    chk("R4 ldPrec", {63'd0, ldPrec}, {63'd0, frRef[20]});
    chk("R1 first bit lands on bit 23 side", {50'd0, refDiv}, 64'h2A5B);

    // R5 R8: divider frame
    frN = nFrame(6'h2D, 13'h1ABC, 1'b1);
    sendBits({8'h0, frN}, 24);
    strobeLe();
    chk("R5 aVal", {58'd0, aVal}, {58'd0, frN[7:2]});
    chk("R5 bVal", {51'd0, bVal}, {51'd0, frN[20:8]});
    chk("R5 gainBit", {63'd0, gainBit}, {63'd0, frN[21]});
    chk("R8 ref kept after N write", {50'd0, refDiv}, 64'h2A5B);

    // R6 R7: function frame, no pulse
    frFn = {2'b10, 1'b1, 3'b101, 3'b011, 4'b1001, 4'b0110, 3'b100, 1'b1, 1'b0, 2'b10};
    sendBits({8'h0, frFn}, 24);
    strobeLe();
    chk("R6 function fields", {42'd0, fnAct}, {42'd0, frFn[23:2]});
    chk("R6 muxSel", {61'd0, muxSel}, {61'd0, frFn[6:4]});
    chk("R7 no pulse on code 10", pulseCnt, 0);
    chk("R8 N kept after function write", {51'd0, bVal}, 64'h1ABC);

    // R3 R7: init code writes function fields and pulses once
    frInit = {2'b01, 1'b0, 3'b010, 3'b110, 4'b0011, 4'b1100, 3'b011, 1'b0, 1'b1, 2'b11};
    sendBits({8'h0, frInit}, 24);
    strobeLe();
    chk("R3 code 11 to function fields", {42'd0, fnAct}, {42'd0, frInit[23:2]});
    chk("R7 one pulse on code 11", pulseCnt, 1);
    chk("R8 ref kept after init write", {48'd0, 2'b0, refDiv}, 64'h2A5B);

    // R11: 30 bits, only last 24 count
    frN2 = nFrame(6'h15, 13'h0F0F, 1'b0);
    sendBits({2'b0, 6'b111111, frN2}, 30);
    strobeLe();
    chk("R11 aVal from last 24 bits", {58'd0, aVal}, {58'd0, frN2[7:2]});
    chk("R11 bVal from last 24 bits", {51'd0, bVal}, {51'd0, frN2[20:8]});

    // R2: data wiggles without serial clock edges are ignored
    frRef2 = refFrame(14'h1234, 2'b01, 2'b10, 1'b0);
    sendBits({8'h0, frRef2}, 24);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); serData = ~serData;
      repeat (2) @(negedge clk);
    end
    strobeLe();
    chk("R2 ref unaffected by data wiggles", {50'd0, refDiv}, {50'd0, frRef2[15:2]});
    chk("R2 abWidth", {62'd0, abWidth}, {62'd0, frRef2[17:16]});
    chk("R7 pulse count unchanged", pulseCnt, 1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule